// File: doc/BRIEF.md
# Permit Line Test Controller

This block sits in front of the four beam permit outputs that feed the interlock network: a maskable and an unmaskable line, each duplicated as an A and a B copy. In normal running it passes the permit decision from upstream logic straight through. A host can ask for a line test. Once the request is set, the block waits until beam info reports no beam. It then forces every permit output false. From that point the host may drive at most one of the four lines true at a time. The test ends only when the host writes a verdict, and the outputs then return to the normal permit decision.

The host reaches the block through a plain register write port made of an enable, an address and data. Every write is taken in the cycle in which the enable is high, and there is no back-pressure. The block carries no streaming data, so it has no valid/ready pair. Status comes back on dedicated pins: test active, request pending, override error, and verdict valid with its pass value.

Top module: `permit_line_test`

## Requirements
- R1: Writing 1 to bit 0 at address 0 while idle sets the request bit (`req_pending`) one clock later. Any write while a test is pending or running leaves the request bit unchanged, except the withdrawal described in R9.
- R2: With the request pending, the test starts (`test_active` high) at the first clock edge at which `beam_info` is low. The block never enters the test while `beam_info` is high.
- R3: In the first test cycle all four permit outputs are 0, and the override error flag is cleared.
- R4: Address 1, bits 3:0, holds the override. Bit 0 is maskable A, bit 1 maskable B, bit 2 unmaskable A and bit 3 unmaskable B. Bits above bit 3 are ignored. During the test, a write with zero or one of these bits set becomes the output pattern one clock later. At most one output is ever true during the test.
- R5: Writing to address 2 during the test ends it one clock later. `result_valid` goes to 1, `result_pass` takes data bit 0 (1 means passed, 0 means failed), and `req_pending` clears. Writing 1 to bit 0 at address 0 while idle clears `result_valid`. A verdict write outside the test has no effect.
- R6: While `beam_info` is high, an override write during the test is ignored. It does not change the outputs and does not set the error flag.
- R7: During the test, an override write with two or more of bits 3:0 set is rejected. The outputs keep their previous pattern, and `ovr_error` goes to 1 one clock later. The flag stays set until the next test entry.
- R8: Whenever no test is running, `permit_out` equals `norm_permit` in the same cycle.
- R9: Writing 0 to bit 0 at address 0 while waiting for entry returns the block to idle. The request bit clears, and the outputs keep following `norm_permit`. If this write arrives in the same cycle as a low `beam_info`, the withdrawal wins.
- R10: Override writes outside the test, and writes to address 3, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_info | input | 1 | High while beam is present |
| norm_permit | input | N_LINES | Normal permit decision, passed through outside the test |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | ADDR_W | Host register address |
| host_wr_data | input | DATA_W | Host write data |
| permit_out | output | N_LINES | Permit lines to the interlock network |
| test_active | output | 1 | Test in progress |
| req_pending | output | 1 | Request bit, set while waiting for the test or during it |
| ovr_error | output | 1 | Override write rejected during the current or last test |
| result_valid | output | 1 | A verdict has been written since the last request |
| result_pass | output | 1 | Last verdict: 1 passed, 0 failed |

## Verification
Every register effect of a host write appears one clock edge after the write cycle. This covers the request bit, entry into the test, a new override pattern, the error flag and the verdict. Entry also comes one edge after `beam_info` is seen low. Outside the test, `permit_out` follows `norm_permit` combinationally in the same cycle. The bench therefore changes inputs just after a falling edge and compares every output at the next falling edge. This puts each sample after exactly one rising edge, using a reference model that it advances once per rising edge.

// File: rtl/pltc_pkg.sv
package pltc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TEST = 2'd2
  } pltc_state_e;

  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_OVERRIDE = 1;
  localparam int unsigned REG_VERDICT  = 2;

  // true when no more than one bit of the vector is set
  function automatic logic at_most_one(input logic [31:0] v, input int unsigned n);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && v[i]) cnt++;
    end
    return (cnt <= 1);
  endfunction

endpackage

// File: rtl/pltc_sequencer.sv
module pltc_sequencer
  import pltc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic beam_info,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  input  logic verdict_wr,
  output logic in_test,
  output logic req_bit,
  output logic arm_pulse,
  output logic enter_pulse,
  output logic leave_pulse
);

  pltc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ctrl_wr && ctrl_bit) state_d = ST_WAIT;
      ST_WAIT: begin
        if (ctrl_wr && !ctrl_bit)  state_d = ST_IDLE;
        else if (!beam_info)       state_d = ST_TEST;
      end
      ST_TEST: if (verdict_wr) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_bit <= 1'b0;
    end else begin
      state_q <= state_d;
      req_bit <= (state_d != ST_IDLE);
    end
  end

  assign in_test     = (state_q == ST_TEST);
  assign arm_pulse   = (state_q == ST_IDLE) && (state_d == ST_WAIT);
  assign enter_pulse = (state_q == ST_WAIT) && (state_d == ST_TEST);
  assign leave_pulse = (state_q == ST_TEST) && (state_d == ST_IDLE);

endmodule

// File: rtl/pltc_override.sv
module pltc_override
  import pltc_pkg::*;
#(
  parameter int unsigned N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beam_info,
  input  logic               in_test,
  input  logic               enter_pulse,
  input  logic               leave_pulse,
  input  logic               ovr_wr,
  input  logic [N_LINES-1:0] ovr_data,
  output logic [N_LINES-1:0] ovr_lines,
  output logic               ovr_error
);

  logic legal;
  logic accept;

  always_comb begin
    logic [31:0] wide;
    wide = '0;
    wide[N_LINES-1:0] = ovr_data;
    legal = at_most_one(wide, N_LINES);
  end

  assign accept = in_test && ovr_wr && !beam_info;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_lines <= '0;
      ovr_error <= 1'b0;
    end else if (enter_pulse) begin
      ovr_lines <= '0;
      ovr_error <= 1'b0;
    end else if (leave_pulse) begin
      ovr_lines <= '0;
    end else if (accept) begin
      if (legal) ovr_lines <= ovr_data;
      else       ovr_error <= 1'b1;
    end
  end

endmodule

// File: rtl/pltc_verdict.sv
module pltc_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_pulse,
  input  logic leave_pulse,
  input  logic verdict_bit,
  output logic result_valid,
  output logic result_pass
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      result_pass  <= 1'b0;
    end else if (arm_pulse) begin
      result_valid <= 1'b0;
    end else if (leave_pulse) begin
      result_valid <= 1'b1;
      result_pass  <= verdict_bit;
    end
  end

endmodule

// File: rtl/pltc_line_mux.sv
module pltc_line_mux #(
  parameter int unsigned N_LINES = 4
) (
  input  logic               in_test,
  input  logic [N_LINES-1:0] norm_lines,
  input  logic [N_LINES-1:0] ovr_lines,
  output logic [N_LINES-1:0] out_lines
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign out_lines[g] = in_test ? ovr_lines[g] : norm_lines[g];
  end

endmodule

// File: rtl/permit_line_test.sv
module permit_line_test
  import pltc_pkg::*;
#(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beam_info,
  input  logic [N_LINES-1:0] norm_permit,
  input  logic               host_wr_en,
  input  logic [ADDR_W-1:0]  host_wr_addr,
  input  logic [DATA_W-1:0]  host_wr_data,
  output logic [N_LINES-1:0] permit_out,
  output logic               test_active,
  output logic               req_pending,
  output logic               ovr_error,
  output logic               result_valid,
  output logic               result_pass
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_OVR  = ADDR_W'(REG_OVERRIDE);
  localparam logic [ADDR_W-1:0] A_VERD = ADDR_W'(REG_VERDICT);

  logic ctrl_wr, ovr_wr, verdict_wr;
  logic in_test, arm_pulse, enter_pulse, leave_pulse;
  logic [N_LINES-1:0] ovr_lines;

  assign ctrl_wr    = host_wr_en && (host_wr_addr == A_CTRL);
  assign ovr_wr     = host_wr_en && (host_wr_addr == A_OVR);
  assign verdict_wr = host_wr_en && (host_wr_addr == A_VERD);

  pltc_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .beam_info   (beam_info),
    .ctrl_wr     (ctrl_wr),
    .ctrl_bit    (host_wr_data[0]),
    .verdict_wr  (verdict_wr),
    .in_test     (in_test),
    .req_bit     (req_pending),
    .arm_pulse   (arm_pulse),
    .enter_pulse (enter_pulse),
    .leave_pulse (leave_pulse)
  );

  pltc_override #(.N_LINES(N_LINES)) u_ovr (
    .clk         (clk),
    .rst_n       (rst_n),
    .beam_info   (beam_info),
    .in_test     (in_test),
    .enter_pulse (enter_pulse),
    .leave_pulse (leave_pulse),
    .ovr_wr      (ovr_wr),
    .ovr_data    (host_wr_data[N_LINES-1:0]),
    .ovr_lines   (ovr_lines),
    .ovr_error   (ovr_error)
  );

  pltc_verdict u_verd (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_pulse    (arm_pulse),
    .leave_pulse  (leave_pulse),
    .verdict_bit  (host_wr_data[0]),
    .result_valid (result_valid),
    .result_pass  (result_pass)
  );

  pltc_line_mux #(.N_LINES(N_LINES)) u_mux (
    .in_test    (in_test),
    .norm_lines (norm_permit),
    .ovr_lines  (ovr_lines),
    .out_lines  (permit_out)
  );

  assign test_active = in_test;

endmodule

// File: rtl/pltc_checker.sv
module pltc_checker #(
  parameter int unsigned N_LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               beam_info,
  input logic [N_LINES-1:0] norm_permit,
  input logic [N_LINES-1:0] permit_out,
  input logic               test_active,
  input logic               req_pending,
  input logic               ovr_error,
  input logic               result_valid
);

  assert_entry_no_beam_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_active) |-> !$past(beam_info));

  assert_entry_all_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_active) |-> (permit_out == '0) && !ovr_error);

  assert_single_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> ($countones(permit_out) <= 1));

  assert_exit_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_active) |-> result_valid && !req_pending);

  assert_beam_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active && $past(test_active) && $past(beam_info)) |-> $stable(permit_out));

  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_error) |-> test_active && $stable(permit_out));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active |-> (permit_out == norm_permit));

  assert_withdraw_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_pending) && !$past(test_active)) |-> !test_active);

  assert_test_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> req_pending);

endmodule

bind permit_line_test pltc_checker #(.N_LINES(N_LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .beam_info    (beam_info),
  .norm_permit  (norm_permit),
  .permit_out   (permit_out),
  .test_active  (test_active),
  .req_pending  (req_pending),
  .ovr_error    (ovr_error),
  .result_valid (result_valid)
);

// File: tb/permit_line_test_tb_top.sv
module permit_line_test_tb_top;

  localparam int NL = 4;
  localparam int AW = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          beam_info = 1'b1;
  logic [NL-1:0] norm_permit = '0;
  logic          host_wr_en = 1'b0;
  logic [AW-1:0] host_wr_addr = '0;
  logic [DW-1:0] host_wr_data = '0;
  logic [NL-1:0] permit_out;
  logic          test_active, req_pending, ovr_error, result_valid, result_pass;

  int checks = 0;
  int errors = 0;

  // reference model state: 0 idle, 1 waiting, 2 testing
  int          m_state = 0;
  logic [NL-1:0] m_ovr = '0;
  logic        m_err = 0, m_rv = 0, m_rp = 0;

  always #5 clk = ~clk;

  permit_line_test #(.N_LINES(NL), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk, .rst_n, .beam_info, .norm_permit, .host_wr_en, .host_wr_addr,
    .host_wr_data, .permit_out, .test_active, .req_pending, .ovr_error,
    .result_valid, .result_pass
  );

  function automatic int ones(input logic [NL-1:0] v);
    int c = 0;
    for (int i = 0; i < NL; i++) c += v[i];
    return c;
  endfunction

  function automatic logic [NL-1:0] exp_permit();
    return (m_state == 2) ? m_ovr : norm_permit;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // advance the model by one rising edge using the inputs now applied
  task automatic model_edge();
    int nxt = m_state;
    logic wr_c = host_wr_en && host_wr_addr == 0;
    logic wr_o = host_wr_en && host_wr_addr == 1;
    logic wr_v = host_wr_en && host_wr_addr == 2;
    case (m_state)
      0: if (wr_c && host_wr_data[0]) begin nxt = 1; m_rv = 0; end
      1: begin
        if (wr_c && !host_wr_data[0]) nxt = 0;
        else if (!beam_info) begin nxt = 2; m_ovr = '0; m_err = 0; end
      end
      default: begin
        if (wr_v) begin
          nxt = 0; m_ovr = '0; m_rv = 1; m_rp = host_wr_data[0];
        end else if (wr_o && !beam_info) begin
          if (ones(host_wr_data[NL-1:0]) <= 1) m_ovr = host_wr_data[NL-1:0];
          else m_err = 1;
        end
      end
    endcase
    m_state = nxt;
  endtask

  task automatic check_all();
    chk("R8/R3/R4/R6/R10 permit_out", permit_out, exp_permit());
    chk("R2 test_active", test_active, m_state == 2);
    chk("R1/R9 req_pending", req_pending, m_state != 0);
    chk("R7 ovr_error", ovr_error, m_err);
    chk("R5 result_valid", result_valid, m_rv);
    chk("R5 result_pass", result_pass, m_rp);
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
    host_wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    host_wr_en = 1'b1;
    host_wr_addr = AW'(a);
    host_wr_data = DW'(d);
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    norm_permit = 4'b1111;
    #1;
    // reset state, pass-through (R8)
    chk("R8 reset passthrough", permit_out, 4'b1111);
    chk("R1 reset req", req_pending, 0);
    chk("R5 reset valid", result_valid, 0);

    // R10: override and verdict while idle ignored
    wr(1, 1); wr(2, 1);
    chk("R10 idle override ignored", permit_out, 4'b1111);
    chk("R5 idle verdict ignored", result_valid, 0);

    // R1/R2: request with beam present: waits
    wr(0, 1);
    chk("R1 request set", req_pending, 1);
    idle(4);
    chk("R2 no entry with beam", test_active, 0);

    // R9: withdraw in same cycle as beam low: withdrawal wins
    beam_info = 1'b0;
    wr(0, 0);
    chk("R9 withdraw", req_pending, 0);
    chk("R9 no entry", test_active, 0);
    chk("R9 outputs follow normal", permit_out, 4'b1111);

    // R2/R3 entry
    wr(0, 1);
    step();
    chk("R2 entered", test_active, 1);
    chk("R3 all low", permit_out, 4'b0000);

    // R4 each line singly; upper bits ignored
    for (int k = 0; k < NL; k++) begin
      wr(1, 8'hF0 | (1 << k));
      chk("R4 single line", permit_out, 1 << k);
    end
    // R7 reject two lines
    wr(1, 4'b0011);
    chk("R7 reject keeps", permit_out, 4'b1000);
    chk("R7 error set", ovr_error, 1);
    wr(1, 0);
    chk("R4 clear lines", permit_out, 0);
    chk("R7 error sticky", ovr_error, 1);

    // R6 beam high: override ignored, no error change
    beam_info = 1'b1;
    wr(1, 4'b0100);
    chk("R6 beam ignored", permit_out, 0);
    wr(0, 0);
    chk("R1 ctrl in test ignored", test_active, 1);

    // R5 verdict fail then pass
    wr(2, 0);
    chk("R5 exit", test_active, 0);
    chk("R5 fail verdict", result_pass, 0);
    chk("R5 valid", result_valid, 1);
    chk("R8 back to normal", permit_out, 4'b1111);
    beam_info = 1'b0;
    wr(0, 1);
    chk("R5 valid cleared on request", result_valid, 0);
    step();
    chk("R3 error cleared on entry", ovr_error, 0);
    wr(2, 1);
    chk("R5 pass verdict", result_pass, 1);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 16 == 0) beam_info = ~beam_info;
      if ($urandom % 8 == 0) norm_permit = NL'($urandom);
      if ($urandom % 3 == 0) begin
        int a = $urandom % 8;
        int d;
        a = (a < 4) ? (a == 3 ? 1 : a) : (a < 7 ? 1 : 3);
        if ($urandom % 2 == 0) d = ($urandom % 5 == 0) ? 0 : (1 << ($urandom % NL));
        else d = $urandom % 256;
        if (a == 0 && $urandom % 4 != 0) d = d | 1;
        if (a == 2 && $urandom % 3 != 0) d = ($urandom % 8 == 0) ? d : 0;
        host_wr_en = 1'b1;
        host_wr_addr = AW'(a);
        host_wr_data = DW'(d);
      end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule